// File: doc/BRIEF.md
# Split Rounding Multiplier

This block is a two-stage pipelined integer multiplier for a 32-bit datapath. One array of four small partial-product multipliers serves two configurations. In packed mode it forms two independent 8x8 products from the low two bytes of each source. In wide mode it forms one 16x16 product from the low halfword of each source. Operands are read as unsigned or as two's complement, as a mode input selects. A rounding option keeps only the upper half of each product, rounded to nearest.

A source pair and its mode bits are presented with a valid strobe. The packed 32-bit result appears with its own valid flag exactly two clock edges later. A new pair may be issued on every cycle. Between results the output word holds its last value.

Top module: `split_round_mul`

## Requirements
- R1: In packed mode (`dualMode`=1, `signedMode`=0, `roundMode`=0) the result holds srcA[7:0]*srcB[7:0] in bits [15:0] and srcA[15:8]*srcB[15:8] in bits [31:16], all unsigned.
- R2: In packed mode with `signedMode`=1, each byte is sign-extended before multiplication, and each 16-bit lane holds the two's-complement product.
- R3: In wide mode (`dualMode`=0, `signedMode`=0, `roundMode`=0) the result is the unsigned 32-bit product srcA[15:0]*srcB[15:0].
- R4: In wide mode with `signedMode`=1, both halfwords are sign-extended, and the result is the 32-bit two's-complement product.
- R5: In packed mode with `roundMode`=1, each lane adds 128 to its 16-bit product and keeps bits [15:8] of the sum. The rounded byte goes in bits [7:0] of the lane, and bits [15:8] of the lane are zero.
- R6: In wide mode with `roundMode`=1, 32768 is added to the 32-bit product. Bits [31:16] of the sum go to result bits [15:0], and result bits [31:16] are zero.
- R7: `outValid` is high exactly on the second rising edge after a rising edge that sampled `inValid` high. Back-to-back issues produce back-to-back results.
- R8: While `rstN` is low, `outValid` is 0 and `product` is 0.
- R9: Source bits [31:16] never affect the result in either mode.
- R10: While `outValid` is low, `product` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Source pair and modes are valid this cycle |
| srcA | input | 32 | First source word |
| srcB | input | 32 | Second source word |
| dualMode | input | 1 | 1: two 8x8 lanes; 0: one 16x16 product |
| signedMode | input | 1 | 1: operands are two's complement |
| roundMode | input | 1 | 1: keep the rounded upper half |
| outValid | output | 1 | Result word is valid |
| product | output | 32 | Packed result word |

## Verification
Each mode combination is driven with corner operands: zero, one, all-ones bytes and halfwords, and the most-negative values. All-ones operands separate the unsigned reading from the signed one. Most-negative times most-negative exposes a missing sign extension or a carry lost in the middle partial products of wide mode. Operands of mixed sign, and products that sit just below and just above the half-LSB point, separate round-to-nearest from truncation. Junk in the upper source halfwords, back-to-back issues that switch modes each cycle, and idle gaps show whether stale lanes, mode mix-ups or a wrong latency leak into the output.

// File: rtl/split_round_mul_pkg.sv
package split_round_mul_pkg;
  typedef struct packed {
    logic s1En;      // capture partial products
    logic s1Dual;    // stage-1 mode: packed lanes
    logic s1Signed;  // stage-1 operand reading
    logic s2En;      // capture final result
    logic s2Dual;    // stage-2 mode: packed lanes
    logic s2Round;   // stage-2 rounding
  } mulStrobe_t;
endpackage

// File: rtl/split_round_mul_ctrl.sv
module split_round_mul_ctrl
  import split_round_mul_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       dualMode,
  input  logic       signedMode,
  input  logic       roundMode,
  output mulStrobe_t stb,
  output logic       outValid
);
  logic v1Q, dual1Q, round1Q, v2Q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1Q     <= 1'b0;
      dual1Q  <= 1'b0;
      round1Q <= 1'b0;
      v2Q     <= 1'b0;
    end else begin
      v1Q <= inValid;
      v2Q <= v1Q;
      if (inValid) begin
        dual1Q  <= dualMode;
        round1Q <= roundMode;
      end
    end
  end

  always_comb begin
    stb.s1En     = inValid;
    stb.s1Dual   = dualMode;
    stb.s1Signed = signedMode;
    stb.s2En     = v1Q;
    stb.s2Dual   = dual1Q;
    stb.s2Round  = round1Q;
  end

  assign outValid = v2Q;
endmodule

// File: rtl/split_round_mul_dp.sv
module split_round_mul_dp
  import split_round_mul_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  mulStrobe_t            stb,
  input  logic [4*LANE_W-1:0]   srcA,
  input  logic [4*LANE_W-1:0]   srcB,
  output logic [4*LANE_W-1:0]   product
);
  localparam int WORD_W = 4 * LANE_W;
  localparam int HALF_W = 2 * LANE_W;
  localparam int EXT_W  = LANE_W + 1;
  localparam int PP_W   = 2 * EXT_W;
  localparam int NUM_PP = 4;

  logic signed [PP_W-1:0] ppQ [NUM_PP];

  // Partial product k: A byte k[0], B byte k[1]
  for (genvar k = 0; k < NUM_PP; k++) begin : g_pp
    localparam int A_SEL = k % 2;
    localparam int B_SEL = k / 2;
    logic               aExtBit, bExtBit;
    logic signed [EXT_W-1:0] aOp, bOp;
    logic signed [PP_W-1:0]  ppD;

    // A high byte is a sign carrier whenever signed; a low byte only in packed mode
    always_comb begin
      aExtBit = stb.s1Signed & (A_SEL == 1 || stb.s1Dual) & srcA[A_SEL*LANE_W + LANE_W-1];
      bExtBit = stb.s1Signed & (B_SEL == 1 || stb.s1Dual) & srcB[B_SEL*LANE_W + LANE_W-1];
      aOp = {aExtBit, srcA[A_SEL*LANE_W +: LANE_W]};
      bOp = {bExtBit, srcB[B_SEL*LANE_W +: LANE_W]};
      ppD = aOp * bOp;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        ppQ[k] <= '0;
      else if (stb.s1En) ppQ[k] <= ppD;
    end
  end

  logic signed [PP_W:0]     midSum;
  logic signed [WORD_W-1:0] midExt, lowExt;
  logic [WORD_W-1:0]        wideFull, wideRnd;
  logic [HALF_W-1:0]        lane0Rnd, lane1Rnd;
  logic [WORD_W-1:0]        resultD;

  always_comb begin
    midSum   = (PP_W+1)'(ppQ[1]) + (PP_W+1)'(ppQ[2]);
    midExt   = WORD_W'(midSum);
    lowExt   = WORD_W'(ppQ[0]);
    wideFull = {ppQ[3][HALF_W-1:0], {HALF_W{1'b0}}}
             + (midExt << LANE_W) + lowExt;
    wideRnd  = wideFull + (WORD_W'(1) << (HALF_W-1));
    lane0Rnd = ppQ[0][HALF_W-1:0] + (HALF_W'(1) << (LANE_W-1));
    lane1Rnd = ppQ[3][HALF_W-1:0] + (HALF_W'(1) << (LANE_W-1));
    case ({stb.s2Dual, stb.s2Round})
      2'b10:   resultD = {ppQ[3][HALF_W-1:0], ppQ[0][HALF_W-1:0]};
      2'b11:   resultD = {{LANE_W{1'b0}}, lane1Rnd[HALF_W-1:LANE_W],
                          {LANE_W{1'b0}}, lane0Rnd[HALF_W-1:LANE_W]};
      2'b01:   resultD = {{HALF_W{1'b0}}, wideRnd[WORD_W-1:HALF_W]};
      default: resultD = wideFull;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         product <= '0;
    else if (stb.s2En) product <= resultD;
  end
endmodule

// File: rtl/split_round_mul.sv
module split_round_mul
  import split_round_mul_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [4*LANE_W-1:0] srcA,
  input  logic [4*LANE_W-1:0] srcB,
  input  logic                dualMode,
  input  logic                signedMode,
  input  logic                roundMode,
  output logic                outValid,
  output logic [4*LANE_W-1:0] product
);
  mulStrobe_t stb;

  split_round_mul_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .dualMode(dualMode),
    .signedMode(signedMode), .roundMode(roundMode), .stb(stb), .outValid(outValid)
  );

  split_round_mul_dp #(.LANE_W(LANE_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .srcA(srcA), .srcB(srcB), .product(product)
  );
endmodule

// File: rtl/split_round_mul_chk.sv
module split_round_mul_chk #(
  parameter int LANE_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic [4*LANE_W-1:0] srcA,
  input logic [4*LANE_W-1:0] srcB,
  input logic                dualMode,
  input logic                signedMode,
  input logic                roundMode,
  input logic                outValid,
  input logic [4*LANE_W-1:0] product
);
  localparam int WORD_W = 4 * LANE_W;
  localparam int HALF_W = 2 * LANE_W;

  logic [1:0]        vSh;
  logic [WORD_W-1:0] a1, a2, b1, b2;
  logic [2:0]        m1, m2; // {dual, signed, round}

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vSh <= '0; a1 <= '0; a2 <= '0; b1 <= '0; b2 <= '0; m1 <= '0; m2 <= '0;
    end else begin
      vSh <= {vSh[0], inValid};
      a1 <= srcA; b1 <= srcB; m1 <= {dualMode, signedMode, roundMode};
      a2 <= a1;   b2 <= b1;   m2 <= m1;
    end
  end

  logic [HALF_W-1:0] refLane0, refLane1;
  logic [WORD_W-1:0] refWide;
  always_comb begin
    refLane0 = HALF_W'(a2[LANE_W-1:0]) * HALF_W'(b2[LANE_W-1:0]);
    refLane1 = HALF_W'(a2[HALF_W-1:LANE_W]) * HALF_W'(b2[HALF_W-1:LANE_W]);
    refWide  = WORD_W'(a2[HALF_W-1:0]) * WORD_W'(b2[HALF_W-1:0]);
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    outValid == vSh[1]);  // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(product));  // R10

  AST_PACKED_UNSIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && m2 == 3'b100) |-> product == {refLane1, refLane0});  // R1

  AST_WIDE_UNSIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && m2 == 3'b000) |-> product == refWide);  // R3

  AST_PACKED_ROUND_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && m2[2] && m2[0]) |->
      (product[HALF_W-1:LANE_W] == '0 && product[WORD_W-1:WORD_W-LANE_W] == '0));  // R5

  AST_WIDE_ROUND_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !m2[2] && m2[0]) |-> product[WORD_W-1:HALF_W] == '0);  // R6

  always @(posedge clk) begin
    if (!rstN) AST_RESET_STATE: assert (outValid == 1'b0);  // R8
  end
endmodule

bind split_round_mul split_round_mul_chk #(.LANE_W(LANE_W)) i_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .srcA(srcA), .srcB(srcB),
  .dualMode(dualMode), .signedMode(signedMode), .roundMode(roundMode),
  .outValid(outValid), .product(product)
);

// File: tb/test_split_round_mul.sv
module test_split_round_mul;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] srcA = '0, srcB = '0;
  logic        dualMode = 1'b0, signedMode = 1'b0, roundMode = 1'b0;
  logic        outValid;
  logic [31:0] product;

  int cyc = 0;
  int nCmp = 0;
  int nBad = 0;
  logic [31:0] expQ [$];
  int          cycQ [$];
  string       tagQ [$];
  logic        done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  split_round_mul i_split_round_mul (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcA(srcA), .srcB(srcB),
    .dualMode(dualMode), .signedMode(signedMode), .roundMode(roundMode),
    .outValid(outValid), .product(product)
  );

  function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b,
                                        logic d, logic s, logic r);
    logic [31:0] res;
    if (d) begin
      res = '0;
      for (int i = 0; i < 2; i++) begin
        int x, y, p;
        if (s) begin x = $signed(a[8*i +: 8]); y = $signed(b[8*i +: 8]); end
        else   begin x = a[8*i +: 8];          y = b[8*i +: 8];          end
        p = x * y;
        if (r) res[16*i +: 16] = {8'h00, 8'((p + 128) >>> 8)};
        else   res[16*i +: 16] = 16'(p);
      end
    end else begin
      longint x, y, p;
      if (s) begin x = $signed(a[15:0]); y = $signed(b[15:0]); end
      else   begin x = a[15:0];          y = b[15:0];          end
      p = x * y;
      if (r) res = {16'h0000, 16'((p + 32768) >>> 16)};
      else   res = 32'(p);
    end
    return res;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: one issue per call, cycle-aligned at the falling edge
  task automatic issue(string tag, logic [31:0] a, logic [31:0] b,
                       logic d, logic s, logic r);
    inValid = 1'b1; srcA = a; srcB = b;
    dualMode = d; signedMode = s; roundMode = r;
    expQ.push_back(model(a, b, d, s, r));
    cycQ.push_back(cyc);
    tagQ.push_back(tag);
    @(negedge clk);
    inValid = 1'b0;
    srcA = 32'hDEAD_BEEF; srcB = 32'h1234_5678;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: pops and compares on each valid result, sampled at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && outValid) begin
        if (expQ.size() == 0) begin
          check("R7 unexpected result", 32'(outValid), 32'd0);
        end else begin
          logic [31:0] e;
          int c;
          string t;
          e = expQ.pop_front(); c = cycQ.pop_front(); t = tagQ.pop_front();
          check(t, product, e);
          check({t, " R7 latency"}, 32'(cyc - c), 32'd2);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    @(negedge clk); @(negedge clk);
    check("R8 reset outValid", 32'(outValid), 32'd0);
    check("R8 reset product", product, 32'd0);
    rstN = 1'b1;
    idle(2);

    // R1 packed unsigned, R9 junk in upper halfword
    issue("R1 packed unsigned ones", 32'hAB00_FFFF, 32'h77CD_FFFF, 1, 0, 0);
    issue("R1 R9 packed unsigned mix", 32'hFFFF_0302, 32'h5A5A_1005, 1, 0, 0);
    // R2 packed signed
    issue("R2 packed signed minus one", 32'h0000_FFFF, 32'h0000_FF01, 1, 1, 0);
    issue("R2 packed signed most-neg", 32'h1234_8080, 32'h9999_807F, 1, 1, 0);
    // R3 wide unsigned
    issue("R3 wide unsigned max", 32'h0000_FFFF, 32'hFFFF_FFFF, 0, 0, 0);
    issue("R3 R9 wide unsigned", 32'hCAFE_1234, 32'hBEEF_0ABC, 0, 0, 0);
    // R4 wide signed
    issue("R4 wide signed most-neg", 32'h0000_8000, 32'h0000_8000, 0, 1, 0);
    issue("R4 wide signed mixed", 32'h7777_FFFE, 32'h0000_7FFF, 0, 1, 0);
    issue("R4 wide signed mid carry", 32'h0000_80FF, 32'h0000_01FF, 0, 1, 0);
    idle(3);
    // R5 packed rounding: 16*8=128 rounds up, 127 rounds down
    issue("R5 packed round unsigned", 32'h0000_7F10, 32'h0000_0108, 1, 0, 1);
    issue("R5 packed round signed", 32'h0000_F0FF, 32'h0000_0880, 1, 1, 1);
    issue("R5 packed round max", 32'h0000_FFFF, 32'h0000_FFFF, 1, 0, 1);
    // R6 wide rounding
    issue("R6 wide round half up", 32'h0000_0100, 32'h0000_0080, 0, 0, 1);
    issue("R6 wide round below half", 32'h0000_7FFF, 32'h0000_0001, 0, 0, 1);
    issue("R6 wide round signed", 32'h0000_FFFF, 32'h0000_8000, 0, 1, 1);
    issue("R6 wide round max", 32'hFFFF_FFFF, 32'h0000_FFFF, 0, 0, 1);
    idle(4);

    // R10 hold while idle
    held = product;
    idle(3);
    check("R10 outValid idle", 32'(outValid), 32'd0);
    check("R10 product held", product, held);

    // R7 back-to-back with mode switching
    for (int i = 0; i < 24; i++) begin
      logic [31:0] a, b;
      a = 32'h9E37_79B9 * (i + 1);
      b = 32'h85EB_CA6B ^ (a << 3);
      issue("R7 back-to-back", a, b, i[0], i[1], i[2]);
    end
    idle(5);
    check("R7 queue drained", 32'(expQ.size()), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule